// File: doc/BRIEF.md
# Strip Descriptor Display Sequencer

This block builds each on-screen-display frame from a table of two-byte strip descriptors held in a 1 KB display RAM. The table is a sequence of horizontal bands, and each band is either empty spacing or a row of characters. On the active edge of the vertical sync, the sequencer returns to the top of the selected page's table. It then walks the table one descriptor at a time and counts scan lines for each band.

A pulse on `lineEvt` marks the start of each scan line. One cycle later the block reports that line to a downstream pixel renderer. The report says whether a strip covers the line and whether it is a character line. It also gives the address of the strip's first character code, the character row to draw, whether characters are drawn, and whether the background must be forced black. Descriptor fetches use a synchronous RAM read port with one cycle of latency. Each fetch happens in the gap between line events, so the next strip is ready by the following line.

Switching pages takes one write to the three-bit page field. Character height, the black-fill choice and the sync polarity come from register fields outside this block.

Top module: `strip_sequencer`

## Requirements
- R1: An active vertical sync edge restarts the frame. With `cfgVsRise`=0 the active edge is falling; with `cfgVsRise`=1 it is rising. The first descriptor is read at address `{cfgPage, 6'b0}`.
- R2: A descriptor is two bytes. The control byte is read first, at an even address, and the second byte at the next odd address. The following descriptor starts 2 bytes later.
- R3: Each `lineEvt` pulse produces a one-cycle `lineStrobe` on the next cycle, together with the fields of that line. The fields hold until the next line.
- R4: A descriptor whose control byte has bit 7 = 0 is a spacing strip lasting (second byte) lines, where a value of 0 counts as 1. Its lines report `lineActive`=1, `lineIsChar`=0, `lineDraw`=0, `lineRow`=0, `lineCodeAddr`=0 and `lineFillBlack`=`cfgFillBlack`.
- R5: A descriptor whose control byte has bit 7 = 1 is a character strip. Its code address is {control[1:0], second[7:1], 0}, which is always even. It lasts `cfgCharHeight` lines, with 0 counting as 1, sampled when the strip starts. It reports rows 0 upward with `lineIsChar`=1.
- R6: Bit 4 of a character strip's control byte doubles the strip. It then lasts twice the height, and each row is reported on two consecutive lines.
- R7: Bit 6 of a character strip's control byte enables drawing. When set, the line reports `lineDraw`=1 and `lineFillBlack`=0. When clear, it reports `lineDraw`=0 and `lineFillBlack`=`cfgFillBlack`.
- R8: A line that arrives before a descriptor is available, for example right after a restart, is idle: `lineActive`, `lineIsChar`, `lineDraw`, `lineFillBlack`, `lineRow` and `lineCodeAddr` are all 0.
- R9: Strips follow one another with no idle line between them, as long as line events are at least 4 cycles apart. An active sync edge in the middle of a strip abandons that strip, and the frame restarts from the first descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsyncIn | input | 1 | Vertical sync level, synchronous to clk |
| cfgVsRise | input | 1 | Active sync edge select: 0 falling, 1 rising |
| lineEvt | input | 1 | One-cycle pulse at the start of each scan line |
| cfgPage | input | 3 | Page holding the descriptor table |
| cfgCharHeight | input | 6 | Character strip height in lines |
| cfgFillBlack | input | 1 | Force black, rather than transparent, on lines with no drawn characters |
| ramRd | output | 1 | RAM read enable |
| ramAddr | output | 10 | RAM read address |
| ramData | input | 8 | RAM read data, valid one cycle after the read |
| lineStrobe | output | 1 | New line report valid |
| lineActive | output | 1 | A strip covers this line |
| lineIsChar | output | 1 | Line belongs to a character strip |
| lineDraw | output | 1 | Characters are drawn on this line |
| lineFillBlack | output | 1 | Background forced black on this line |
| lineRow | output | 6 | Character row within the strip |
| lineCodeAddr | output | 10 | Address of the strip's first character code |

## Verification
The assertions check on every cycle that properties which hold line by line stay true. A restart's first read goes to the page base, and the two byte reads of a fetch follow each other. A captured descriptor becomes ready. Drawn lines are always character lines without black fill, and spacing lines carry no row or code address. Strip lengths, the doubled-row order, zero-length clamping, idle lines before the first fetch, abandoning a strip on a sync edge, and the selection of page and polarity all depend on a sequence of lines. Only the bench's directed scenarios can show these, by comparing every reported line with the table they wrote.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic restart;  // active vertical sync edge
    logic rdHi;     // read control byte
    logic rdLo;     // read second byte, capture control byte
    logic capLo;    // capture second byte, descriptor ready
  } seqCtrl_t;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_HI   = 2'd1,
    F_LO   = 2'd2,
    F_CAP  = 2'd3
  } fetchSt_t;

endpackage

// File: rtl/strip_seq_ctrl.sv
module strip_seq_ctrl
  import strip_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     vsyncIn,
  input  logic     cfgVsRise,
  input  logic     fetchNeed,
  output seqCtrl_t strobes
);

  logic     vsPrev;
  logic     vsEdge;
  fetchSt_t st, stNext;

  assign vsEdge = cfgVsRise ? (vsyncIn & ~vsPrev) : (~vsyncIn & vsPrev);

  always_comb begin
    stNext = st;
    if (vsEdge) stNext = F_HI;
    else begin
      case (st)
        F_IDLE:  if (fetchNeed) stNext = F_HI;
        F_HI:    stNext = F_LO;
        F_LO:    stNext = F_CAP;
        default: stNext = F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsPrev <= 1'b0;
      st     <= F_IDLE;
    end else begin
      vsPrev <= vsyncIn;
      st     <= stNext;
    end
  end

  assign strobes.restart = vsEdge;
  assign strobes.rdHi    = (st == F_HI);
  assign strobes.rdLo    = (st == F_LO);
  assign strobes.capLo   = (st == F_CAP);

  // R2: the second byte read always follows the control byte read
  a_r2_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rdHi && !strobes.restart |=> strobes.rdLo);

  // R2: the descriptor is captured right after the second byte read
  a_r2_lo_then_cap: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rdLo && !strobes.restart |=> strobes.capLo);

endmodule

// File: rtl/strip_seq_datapath.sv
module strip_seq_datapath
  import strip_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 3,
  parameter int HEIGHT_W = 6,
  parameter int LEN_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  seqCtrl_t            strobes,
  input  logic                lineEvt,
  input  logic [PAGE_W-1:0]   cfgPage,
  input  logic [HEIGHT_W-1:0] cfgCharHeight,
  input  logic                cfgFillBlack,
  input  logic [7:0]          ramData,
  output logic                ramRd,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic                fetchNeed,
  output logic                lineStrobe,
  output logic                lineActive,
  output logic                lineIsChar,
  output logic                lineDraw,
  output logic                lineFillBlack,
  output logic [HEIGHT_W-1:0] lineRow,
  output logic [ADDR_W-1:0]   lineCodeAddr
);

  localparam int PAGE_SHIFT = ADDR_W - 1 - PAGE_W;
  localparam int CODE_HI_W  = ADDR_W - 8;

  logic [ADDR_W-1:0] ptr;
  logic [7:0]        descHi, descLo;
  logic              descReady;

  logic              stripLive;
  logic              curChar, curDe, curZy;
  logic [ADDR_W-1:0] curCode;
  logic [LEN_W-1:0]  curLen, lineNo;

  // Decode of the pending descriptor
  logic                newChar, newDe, newZy;
  logic [ADDR_W-1:0]   newCode;
  logic [HEIGHT_W-1:0] heightEff;
  logic [LEN_W-1:0]    newLen;
  logic                newLast, liveLast;
  logic [HEIGHT_W-1:0] liveRow;

  assign newChar   = descHi[7];
  assign newDe     = descHi[6];
  assign newZy     = descHi[4];
  assign newCode   = {descHi[CODE_HI_W-1:0], descLo[7:1], 1'b0};
  assign heightEff = (cfgCharHeight == '0) ? HEIGHT_W'(1) : cfgCharHeight;

  always_comb begin
    if (newChar)
      newLen = newZy ? LEN_W'({heightEff, 1'b0}) : LEN_W'(heightEff);
    else
      newLen = (descLo == 8'd0) ? LEN_W'(1) : LEN_W'(descLo);
  end

  assign newLast  = (newLen == LEN_W'(1));
  assign liveLast = ((lineNo + LEN_W'(1)) == curLen);
  assign liveRow  = curZy ? lineNo[HEIGHT_W:1] : lineNo[HEIGHT_W-1:0];

  assign ramRd   = strobes.rdHi | strobes.rdLo;
  assign ramAddr = strobes.rdLo ? (ptr | ADDR_W'(1)) : ptr;

  assign fetchNeed = lineEvt & ~strobes.restart &
                     ((stripLive & liveLast) | (~stripLive & descReady & newLast));

  // Descriptor fetch and strip state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      descHi    <= '0;
      descLo    <= '0;
      descReady <= 1'b0;
      stripLive <= 1'b0;
      curChar   <= 1'b0;
      curDe     <= 1'b0;
      curZy     <= 1'b0;
      curCode   <= '0;
      curLen    <= '0;
      lineNo    <= '0;
    end else if (strobes.restart) begin
      ptr       <= {1'b0, cfgPage, {PAGE_SHIFT{1'b0}}};
      descReady <= 1'b0;
      stripLive <= 1'b0;
    end else begin
      if (strobes.rdLo) descHi <= ramData;
      if (strobes.capLo) begin
        descLo    <= ramData;
        descReady <= 1'b1;
        ptr       <= ptr + ADDR_W'(2);
      end
      if (lineEvt) begin
        if (stripLive) begin
          lineNo <= lineNo + LEN_W'(1);
          if (liveLast) stripLive <= 1'b0;
        end else if (descReady) begin
          curChar   <= newChar;
          curDe     <= newDe;
          curZy     <= newZy;
          curCode   <= newCode;
          curLen    <= newLen;
          lineNo    <= LEN_W'(1);
          stripLive <= ~newLast;
          descReady <= 1'b0;
        end
      end
    end
  end

  // Line report
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineStrobe    <= 1'b0;
      lineActive    <= 1'b0;
      lineIsChar    <= 1'b0;
      lineDraw      <= 1'b0;
      lineFillBlack <= 1'b0;
      lineRow       <= '0;
      lineCodeAddr  <= '0;
    end else begin
      lineStrobe <= lineEvt;
      if (lineEvt) begin
        if (!strobes.restart && stripLive) begin
          lineActive    <= 1'b1;
          lineIsChar    <= curChar;
          lineDraw      <= curChar & curDe;
          lineFillBlack <= ~(curChar & curDe) & cfgFillBlack;
          lineRow       <= curChar ? liveRow : '0;
          lineCodeAddr  <= curChar ? curCode : '0;
        end else if (!strobes.restart && descReady) begin
          lineActive    <= 1'b1;
          lineIsChar    <= newChar;
          lineDraw      <= newChar & newDe;
          lineFillBlack <= ~(newChar & newDe) & cfgFillBlack;
          lineRow       <= '0;
          lineCodeAddr  <= newChar ? newCode : '0;
        end else begin
          lineActive    <= 1'b0;
          lineIsChar    <= 1'b0;
          lineDraw      <= 1'b0;
          lineFillBlack <= 1'b0;
          lineRow       <= '0;
          lineCodeAddr  <= '0;
        end
      end
    end
  end

  // R1: the read after a restart targets the selected page base
  a_r1_page_base: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.restart |=> ramRd && (ramAddr == {1'b0, $past(cfgPage), {PAGE_SHIFT{1'b0}}}));

  // R2: a captured descriptor is ready for the next line
  a_r2_ready_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capLo && !strobes.restart |=> descReady || lineStrobe);

  // R7: drawing only happens on active character lines without black fill
  a_r7_draw_is_char: assert property (@(posedge clk) disable iff (!rst_n)
    lineStrobe && lineDraw |-> lineIsChar && lineActive && !lineFillBlack);

  // R4: spacing lines carry neither row nor code address
  a_r4_spacing_clean: assert property (@(posedge clk) disable iff (!rst_n)
    lineStrobe && !lineIsChar |-> (lineRow == '0) && (lineCodeAddr == '0));

  // R5: character code addresses are even
  a_r5_even_code: assert property (@(posedge clk) disable iff (!rst_n)
    lineStrobe && lineIsChar |-> !lineCodeAddr[0]);

  // R8: an idle line reports nothing to draw or fill
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lineStrobe && !lineActive |-> !lineDraw && !lineFillBlack && !lineIsChar);

endmodule

// File: rtl/strip_sequencer.sv
module strip_sequencer
  import strip_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 3,
  parameter int HEIGHT_W = 6,
  parameter int LEN_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vsyncIn,
  input  logic                cfgVsRise,
  input  logic                lineEvt,
  input  logic [PAGE_W-1:0]   cfgPage,
  input  logic [HEIGHT_W-1:0] cfgCharHeight,
  input  logic                cfgFillBlack,
  output logic                ramRd,
  output logic [ADDR_W-1:0]   ramAddr,
  input  logic [7:0]          ramData,
  output logic                lineStrobe,
  output logic                lineActive,
  output logic                lineIsChar,
  output logic                lineDraw,
  output logic                lineFillBlack,
  output logic [HEIGHT_W-1:0] lineRow,
  output logic [ADDR_W-1:0]   lineCodeAddr
);

  seqCtrl_t strobes;
  logic     fetchNeed;

  strip_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsyncIn   (vsyncIn),
    .cfgVsRise (cfgVsRise),
    .fetchNeed (fetchNeed),
    .strobes   (strobes)
  );

  strip_seq_datapath #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .HEIGHT_W (HEIGHT_W),
    .LEN_W    (LEN_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .lineEvt       (lineEvt),
    .cfgPage       (cfgPage),
    .cfgCharHeight (cfgCharHeight),
    .cfgFillBlack  (cfgFillBlack),
    .ramData       (ramData),
    .ramRd         (ramRd),
    .ramAddr       (ramAddr),
    .fetchNeed     (fetchNeed),
    .lineStrobe    (lineStrobe),
    .lineActive    (lineActive),
    .lineIsChar    (lineIsChar),
    .lineDraw      (lineDraw),
    .lineFillBlack (lineFillBlack),
    .lineRow       (lineRow),
    .lineCodeAddr  (lineCodeAddr)
  );

endmodule

// File: tb/strip_sequencer_bench.sv
module strip_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsyncIn = 1'b1;
  logic       cfgVsRise = 1'b0;
  logic       lineEvt = 1'b0;
  logic [2:0] cfgPage = 3'd0;
  logic [5:0] cfgCharHeight = 6'd2;
  logic       cfgFillBlack = 1'b1;
  logic       ramRd;
  logic [9:0] ramAddr;
  logic [7:0] ramData = 8'd0;
  logic       lineStrobe, lineActive, lineIsChar, lineDraw, lineFillBlack;
  logic [5:0] lineRow;
  logic [9:0] lineCodeAddr;

  logic [7:0] mem [1024];
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (ramRd) ramData <= mem[ramAddr];

  strip_sequencer u_strip_sequencer (
    .clk(clk), .rst_n(rst_n), .vsyncIn(vsyncIn), .cfgVsRise(cfgVsRise),
    .lineEvt(lineEvt), .cfgPage(cfgPage), .cfgCharHeight(cfgCharHeight),
    .cfgFillBlack(cfgFillBlack), .ramRd(ramRd), .ramAddr(ramAddr),
    .ramData(ramData), .lineStrobe(lineStrobe), .lineActive(lineActive),
    .lineIsChar(lineIsChar), .lineDraw(lineDraw), .lineFillBlack(lineFillBlack),
    .lineRow(lineRow), .lineCodeAddr(lineCodeAddr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic lineCheck(input string req, input bit act, input bit isChr, input bit drw,
                           input bit fill, input int row, input int code);
    chk(req, "lineStrobe", int'(lineStrobe), 1);
    chk(req, "lineActive", int'(lineActive), int'(act));
    chk(req, "lineIsChar", int'(lineIsChar), int'(isChr));
    chk(req, "lineDraw", int'(lineDraw), int'(drw));
    chk(req, "lineFillBlack", int'(lineFillBlack), int'(fill));
    chk(req, "lineRow", int'(lineRow), row);
    chk(req, "lineCodeAddr", int'(lineCodeAddr), code);
  endtask

  // One scan line: pulse, then sample the report one cycle later
  task automatic doLine(input string req, input bit act, input bit isChr, input bit drw,
                        input bit fill, input int row, input int code);
    @(negedge clk) lineEvt = 1'b1;
    @(negedge clk) lineEvt = 1'b0;
    lineCheck(req, act, isChr, drw, fill, row, code);
    repeat (6) @(negedge clk);
  endtask

  // Active sync edge for the current polarity, then back to idle
  task automatic fireSync();
    @(negedge clk) vsyncIn = cfgVsRise;
    @(negedge clk) vsyncIn = ~cfgVsRise;
    repeat (6) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R3", "reset lineStrobe", int'(lineStrobe), 0);
    chk("R3", "reset ramRd", int'(ramRd), 0);
    chk("R8", "reset lineActive", int'(lineActive), 0);
  endtask

  // Page 0: mixed strips, zoom, zero lengths, back to back
  task automatic tTableWalk();
    fireSync();
    for (int i = 0; i < 3; i++) doLine("R4", 1, 0, 0, 1, 0, 0);
    doLine("R5", 1, 1, 1, 0, 0, 'h102);
    doLine("R7", 1, 1, 1, 0, 1, 'h102);
    doLine("R6", 1, 1, 0, 1, 0, 'h3FE);
    doLine("R6", 1, 1, 0, 1, 0, 'h3FE);
    doLine("R6", 1, 1, 0, 1, 1, 'h3FE);
    doLine("R7", 1, 1, 0, 1, 1, 'h3FE);
    doLine("R4", 1, 0, 0, 1, 0, 0);       // zero-length spacing is one line
    cfgCharHeight = 6'd0;
    doLine("R5", 1, 1, 0, 1, 0, 'h010);   // zero height is one line
    cfgCharHeight = 6'd2;
    doLine("R9", 1, 0, 0, 1, 0, 0);       // next spacing follows directly
  endtask

  // Sync mid-strip abandons it and restarts from the table top
  task automatic tRestart();
    fireSync();
    for (int i = 0; i < 3; i++) doLine("R9", 1, 0, 0, 1, 0, 0);
    doLine("R9", 1, 1, 1, 0, 0, 'h102);
  endtask

  // A line right after the sync edge arrives before the fetch completes
  task automatic tEarlyLine();
    @(negedge clk) vsyncIn = 1'b0;
    @(negedge clk) begin vsyncIn = 1'b1; lineEvt = 1'b1; end
    @(negedge clk) lineEvt = 1'b0;
    lineCheck("R8", 0, 0, 0, 0, 0, 0);
    repeat (6) @(negedge clk);
    doLine("R8", 1, 0, 0, 1, 0, 0);
  endtask

  // Rising polarity, page 5, zoomed height 3, transparent fill
  task automatic tPageRise();
    cfgFillBlack = 1'b0;
    @(negedge clk) vsyncIn = 1'b0;
    @(negedge clk) cfgVsRise = 1'b1;
    cfgPage = 3'd5;
    cfgCharHeight = 6'd3;
    repeat (2) @(negedge clk);
    fireSync();
    for (int r = 0; r < 3; r++) begin
      doLine("R1", 1, 1, 1, 0, r, 'h046);
      doLine("R6", 1, 1, 1, 0, r, 'h046);
    end
    doLine("R4", 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    mem[0] = 8'h00; mem[1] = 8'h03;    // spacing, 3 lines
    mem[2] = 8'hC1; mem[3] = 8'h02;    // char, drawn, code 0x102
    mem[4] = 8'h93; mem[5] = 8'hFF;    // char, hidden, doubled, code 0x3FE
    mem[6] = 8'h00; mem[7] = 8'h00;    // spacing, zero length
    mem[8] = 8'h80; mem[9] = 8'h10;    // char, hidden, code 0x010
    mem[10] = 8'h00; mem[11] = 8'h02;  // spacing, 2 lines
    mem['h140] = 8'hD0; mem['h141] = 8'h46;  // char, drawn, doubled, code 0x046
    mem['h142] = 8'h00; mem['h143] = 8'h02;  // spacing, 2 lines
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tTableWalk();
    tRestart();
    tEarlyLine();
    tPageRise();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule